// File: doc/BRIEF.md
# Three-Channel Multi-Mode Interval Timer

This block holds a bank of independent general-purpose timers, three by default. Each channel owns one pin, carried as separate input, output and output-enable signals. It can run in one of three modes. In waveform mode it generates a periodic pulse train on its pin. In capture mode it measures the high time and the full period of a pulse train arriving on its pin. In watchdog mode it raises an alarm when too few pin edges arrive within a time window. Every mode produces a periodic event that sets a flag in a single status register shared by all channels. Each channel can forward its flag to its own interrupt request line.

Software reaches the block through a simple synchronous register bus. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of `bus_addr`. Each channel has four word slots at base `4*t`: configuration, count, period and width. The status register follows the last channel, at address 12 in the default build.

Top module: `gp_timer_bank`

## Requirements
- R1: Channel t decodes addresses 4t (config), 4t+1 (count), 4t+2 (period) and 4t+3 (width), and the status register sits at address 12. A write to one channel's slot changes no register, pin or flag of any other channel.
- R2: The config layout is as follows. Bit 0 is enable. Bits 2:1 are the mode: 0 idle, 1 waveform, 2 capture, 3 watchdog. Bit 3 is invert, bit 4 is interrupt enable, and bits 6:5 are spare bits that always read 0. A channel that is disabled or in idle mode holds its count at 0, leaves its pin undriven (output 0, enable 0) and raises no event. Any config write restarts the count at 0.
- R3: In waveform mode the count steps 0, 1, ..., P-1, 0, ... with one step per clock, where P is the period register (P of 0 or 1 behaves as 1). The pin output is high while count < W (the width register), XOR the invert bit, and the pin is driven.
- R4: In waveform mode an event fires in the cycle where the count equals P-1. Its flag is readable from the following cycle.
- R5: In capture mode the pin is sampled through a two-stage synchronizer. The leading edge is rising, or falling when invert is set. The first leading edge after a config write only arms the channel. After that, each trailing edge loads the width register with the clocks since the last leading edge. Each further leading edge loads the period register with the clocks since the previous leading edge and raises an event.
- R6: In watchdog mode the count steps through a window of P clocks (0..P-1) while leading pin edges are tallied. At the window's last cycle an event fires if the tally is below W. Both count and tally then restart.
- R7: Status bit t is channel t's event flag and bit 3+t is its overflow flag. Writing 1 to a bit clears it and writing 0 leaves it unchanged. An event that arrives in the same cycle as its clear wins, and the flag stays set.
- R8: An overflow flag sets when its channel raises an event while that channel's event flag is already set.
- R9: Interrupt request t is high exactly while event flag t is set and config bit 4 of channel t is 1.
- R10: Period and width are writable by software, and a software write wins over a capture in the same cycle. Writes to the count slot are ignored.
- R11: After reset every register reads 0, and no pin is driven and no interrupt is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| tmr_pin_i | input | N_TMR (3) | Sampled level of each channel pin |
| tmr_pin_o | output | N_TMR (3) | Level driven onto each channel pin |
| tmr_pin_oe | output | N_TMR (3) | Drive enable of each channel pin |
| tmr_irq | output | N_TMR (3) | Interrupt request per channel |

## Verification
The bound checker watches the status logic on every cycle. It checks that no flag rises without an event from its channel, that every event leaves its flag set, that overflow appears only on a repeated event, and that interrupt lines never run ahead of their flags. It also checks that an idle channel neither drives its pin nor raises an event. Only the bench scenarios can show the timing itself: the waveform level per count, the exact cycle of the waveform event, and the width and period values captured from a pulse train. The same holds for the watchdog boundary between exactly W edges and one fewer, and for register isolation between channels.

// File: rtl/gptmr_pkg.sv
package gptmr_pkg;

    localparam int CFG_W        = 7;
    localparam int REGS_PER_TMR = 4;
    localparam int SLOT_W       = 2;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_WAVE = 2'd1,
        MODE_CAPT = 2'd2,
        MODE_WDOG = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SLOT_CFG = 2'd0,
        SLOT_CNT = 2'd1,
        SLOT_PER = 2'd2,
        SLOT_WID = 2'd3
    } tmr_slot_e;

    typedef struct packed {
        logic [1:0] spare;
        logic       irq_en;
        logic       invert;
        tmr_mode_e  mode;
        logic       enable;
    } tmr_cfg_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } pin_edge_t;

    // Spare bits never hold state.
    function automatic tmr_cfg_t cfg_from_bus(input logic [CFG_W-1:0] raw);
        tmr_cfg_t c;
        c       = tmr_cfg_t'(raw);
        c.spare = 2'b00;
        return c;
    endfunction

    function automatic logic cfg_running(input tmr_cfg_t c);
        return c.enable && (c.mode != MODE_IDLE);
    endfunction

endpackage

// File: rtl/gptmr_edge_det.sv
module gptmr_edge_det
    import gptmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  logic      invert,
    output pin_edge_t edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign cur = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur;
    end

    // History holds the raw level, so flipping invert never fakes an edge.
    always_comb begin
        edge_o.lead  = invert ? (prev_q & ~cur) : (~prev_q & cur);
        edge_o.trail = invert ? (~prev_q & cur) : (prev_q & ~cur);
    end

endmodule

// File: rtl/gptmr_channel.sv
module gptmr_channel
    import gptmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cfg,
    input  logic             wr_per,
    input  logic             wr_wid,
    input  logic [CNT_W-1:0] wdata,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe,
    output tmr_cfg_t         cfg_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] wid_o,
    output logic             run_o,
    output logic             evt_o
);

    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W:0]   ONE_X   = {{CNT_W{1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic [CNT_W-1:0] wid_q, wid_d;
    logic [CNT_W-1:0] hits_q, hits_d, hits_sum;
    logic             armed_q, armed_d;
    logic             running, at_end, evt;
    pin_edge_t        pe;

    gptmr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .invert (cfg_q.invert),
        .edge_o (pe)
    );

    assign running  = cfg_running(cfg_q);
    assign at_end   = ({1'b0, cnt_q} + ONE_X) >= {1'b0, per_q};
    assign hits_sum = (pe.lead && (hits_q != CNT_MAX)) ? hits_q + ONE : hits_q;

    always_comb begin
        cnt_d   = cnt_q;
        per_d   = per_q;
        wid_d   = wid_q;
        hits_d  = hits_q;
        armed_d = armed_q;
        evt     = 1'b0;
        if (!running) begin
            cnt_d   = '0;
            hits_d  = '0;
            armed_d = 1'b0;
        end else begin
            case (cfg_q.mode)
                MODE_WAVE: begin
                    if (at_end) begin
                        cnt_d = '0;
                        evt   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                MODE_CAPT: begin
                    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE;
                    if (pe.trail && armed_q) wid_d = cnt_q;
                    if (pe.lead) begin
                        if (armed_q) begin
                            per_d = cnt_q;
                            evt   = 1'b1;
                        end
                        armed_d = 1'b1;
                        cnt_d   = ONE;
                    end
                end
                MODE_WDOG: begin
                    if (at_end) begin
                        evt    = (hits_sum < wid_q);
                        cnt_d  = '0;
                        hits_d = '0;
                    end else begin
                        cnt_d  = cnt_q + ONE;
                        hits_d = hits_sum;
                    end
                end
                default: cnt_d = '0;
            endcase
        end
        if (wr_per) per_d = wdata;
        if (wr_wid) wid_d = wdata;
        if (wr_cfg) begin
            cnt_d   = '0;
            hits_d  = '0;
            armed_d = 1'b0;
            evt     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            per_q   <= '0;
            wid_q   <= '0;
            hits_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= cfg_from_bus(wdata[CFG_W-1:0]);
            cnt_q   <= cnt_d;
            per_q   <= per_d;
            wid_q   <= wid_d;
            hits_q  <= hits_d;
            armed_q <= armed_d;
        end
    end

    assign pin_oe = running && (cfg_q.mode == MODE_WAVE);
    assign pin_o  = pin_oe && ((cnt_q < wid_q) ^ cfg_q.invert);
    assign cfg_o  = cfg_q;
    assign cnt_o  = cnt_q;
    assign per_o  = per_q;
    assign wid_o  = wid_q;
    assign run_o  = running;
    assign evt_o  = evt;

endmodule

// File: rtl/gptmr_status.sv
module gptmr_status #(
    parameter int N_TMR = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_TMR-1:0]   evt_i,
    input  logic               clr_we,
    input  logic [2*N_TMR-1:0] clr_bits,
    input  logic [N_TMR-1:0]   irq_en_i,
    output logic [N_TMR-1:0]   flag_o,
    output logic [N_TMR-1:0]   ovf_o,
    output logic [N_TMR-1:0]   irq_o
);

    generate
        for (genvar t = 0; t < N_TMR; t++) begin : g_bit
            logic flag_q, ovf_q, kill_flag, kill_ovf;

            assign kill_flag = clr_we && clr_bits[t];
            assign kill_ovf  = clr_we && clr_bits[N_TMR+t];

            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                    ovf_q  <= 1'b0;
                end else begin
                    flag_q <= (flag_q && !kill_flag) || evt_i[t];
                    ovf_q  <= (ovf_q && !kill_ovf) || (evt_i[t] && flag_q && !kill_flag);
                end
            end

            assign flag_o[t] = flag_q;
            assign ovf_o[t]  = ovf_q;
            assign irq_o[t]  = flag_q && irq_en_i[t];
        end
    endgenerate

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
    import gptmr_pkg::*;
#(
    parameter int  N_TMR       = 3,
    parameter int  CNT_W       = 32,
    parameter int  SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(N_TMR*REGS_PER_TMR + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [N_TMR-1:0]  tmr_pin_i,
    output logic [N_TMR-1:0]  tmr_pin_o,
    output logic [N_TMR-1:0]  tmr_pin_oe,
    output logic [N_TMR-1:0]  tmr_irq
);

    localparam int              IDX_W     = ADDR_W - SLOT_W;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_TMR*REGS_PER_TMR);

    tmr_cfg_t         cfg_a [N_TMR];
    logic [CNT_W-1:0] cnt_a [N_TMR];
    logic [CNT_W-1:0] per_a [N_TMR];
    logic [CNT_W-1:0] wid_a [N_TMR];
    logic [N_TMR-1:0] evt_v, run_v, irqen_v, flag_v, ovf_v;

    tmr_slot_e        slot;
    logic [IDX_W-1:0] idx;
    logic             stat_we;

    assign slot    = tmr_slot_e'(bus_addr[SLOT_W-1:0]);
    assign idx     = bus_addr[ADDR_W-1:SLOT_W];
    assign stat_we = bus_we && (bus_addr == STAT_ADDR);

    generate
        for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
            logic hit;
            assign hit = bus_we && (idx == IDX_W'(t));

            gptmr_channel #(
                .CNT_W       (CNT_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_chan (
                .clk    (clk),
                .rst    (rst),
                .wr_cfg (hit && (slot == SLOT_CFG)),
                .wr_per (hit && (slot == SLOT_PER)),
                .wr_wid (hit && (slot == SLOT_WID)),
                .wdata  (bus_wdata),
                .pin_i  (tmr_pin_i[t]),
                .pin_o  (tmr_pin_o[t]),
                .pin_oe (tmr_pin_oe[t]),
                .cfg_o  (cfg_a[t]),
                .cnt_o  (cnt_a[t]),
                .per_o  (per_a[t]),
                .wid_o  (wid_a[t]),
                .run_o  (run_v[t]),
                .evt_o  (evt_v[t])
            );

            assign irqen_v[t] = cfg_a[t].irq_en;
        end
    endgenerate

    gptmr_status #(.N_TMR(N_TMR)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_v),
        .clr_we   (stat_we),
        .clr_bits (bus_wdata[2*N_TMR-1:0]),
        .irq_en_i (irqen_v),
        .flag_o   (flag_v),
        .ovf_o    (ovf_v),
        .irq_o    (tmr_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR) bus_rdata[2*N_TMR-1:0] = {ovf_v, flag_v};
        for (int t = 0; t < N_TMR; t++) begin
            if (idx == IDX_W'(t)) begin
                case (slot)
                    SLOT_CFG: bus_rdata[CFG_W-1:0] = cfg_a[t];
                    SLOT_CNT: bus_rdata = cnt_a[t];
                    SLOT_PER: bus_rdata = per_a[t];
                    default:  bus_rdata = wid_a[t];
                endcase
            end
        end
    end

endmodule

// File: rtl/gptmr_bank_chk.sv
module gptmr_bank_chk #(
    parameter int N_TMR = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_TMR-1:0] evt,
    input logic [N_TMR-1:0] flag,
    input logic [N_TMR-1:0] ovf,
    input logic [N_TMR-1:0] run,
    input logic [N_TMR-1:0] irq,
    input logic [N_TMR-1:0] oe
);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (irq & ~flag) == '0); // R9

    AST_EVT_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flag & $past(evt)) == $past(evt))); // R7

    AST_FLAG_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag)) & ~$past(evt)) == '0); // R7

    AST_OVF_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
        ((ovf & ~$past(ovf)) & ~($past(flag) & $past(evt))) == '0); // R8

    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (evt & ~run) == '0); // R2

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (oe & ~run) == '0); // R2

endmodule

bind gp_timer_bank gptmr_bank_chk #(.N_TMR(N_TMR)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt_v),
    .flag (flag_v),
    .ovf  (ovf_v),
    .run  (run_v),
    .irq  (tmr_irq),
    .oe   (tmr_pin_oe)
);

// File: tb/gp_timer_bank_tb_top.sv
module gp_timer_bank_tb_top;

    localparam int N      = 3;
    localparam int CW     = 32;
    localparam int AW     = 4;
    localparam int CLK_NS = 8;
    localparam int STAT   = 12;
    localparam int EN = 1, WAVE = 2, CAPT = 4, WDOG = 6, INV = 8, IEN = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, irq;
    int            total = 0;
    int            bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    gp_timer_bank #(.N_TMR(N), .CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tmr_pin_i  (pin_in),
        .tmr_pin_o  (pin_out),
        .tmr_pin_oe (pin_oe),
        .tmr_irq    (irq)
    );

    function automatic int A(input int t, input int slot);
        return t*4 + slot;
    endfunction

    function automatic logic exp_wave(input int j, input int p, input int w, input bit inv);
        int pp;
        pp = (p < 1) ? 1 : p;
        return ((j % pp) < w) ^ inv;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic run_capture(input int t, input int hi, input int lo, input bit inv, input bit ien);
        logic [31:0] d;
        pin_in[t] = 1'b0;
        repeat (4) @(negedge clk);
        wr(A(t,0), EN | CAPT | (inv ? INV : 0) | (ien ? IEN : 0));
        wr(STAT, 32'h3F);
        for (int k = 0; k < 3; k++) begin
            pin_in[t] = 1'b1;
            repeat (hi) @(negedge clk);
            pin_in[t] = 1'b0;
            repeat (lo) @(negedge clk);
        end
        pin_in[t] = 1'b1;
        repeat (5) @(negedge clk);
        rd(A(t,2), d); check("R5 captured period", d, hi + lo);
        rd(A(t,3), d); check("R5 captured width", d, inv ? lo : hi);
        rd(STAT, d);   check("R8 capture flags", d, (32'd1 << t) | (32'd1 << (t+3)));
        check("R9 capture irq", irq[t], ien);
        check("R5 capture pin undriven", pin_oe[t], 1'b0);
        wr(A(t,0), 0);
        pin_in[t] = 1'b0;
        wr(STAT, 32'h3F);
    endtask

    initial begin
        #(CLK_NS*150000);
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        for (int a = 0; a <= STAT; a++) begin
            rd(a, d);
            check("R11 reset register", d, 0);
        end
        check("R11 reset pin_oe", pin_oe, 0);
        check("R11 reset irq", irq, 0);

        // R2 spare bits, idle and disabled modes
        wr(A(1,0), 32'h60);
        rd(A(1,0), d); check("R2 spare bits read zero", d, 0);
        wr(A(1,0), 32'h61);
        repeat (3) @(negedge clk);
        rd(A(1,0), d); check("R2 idle config readback", d, 1);
        rd(A(1,1), d); check("R2 idle count held", d, 0);
        wr(A(1,0), WAVE);
        repeat (3) @(negedge clk);
        rd(A(1,1), d); check("R2 disabled count held", d, 0);
        check("R2 disabled pin undriven", pin_oe, 0);
        rd(STAT, d);   check("R2 no events while idle", d, 0);
        wr(A(1,0), 0);

        // R1 isolation, R10 count not writable
        wr(A(0,2), 11); wr(A(1,2), 22); wr(A(2,2), 33); wr(A(1,1), 55);
        rd(A(0,2), d); check("R1 period t0", d, 11);
        rd(A(1,2), d); check("R1 period t1", d, 22);
        rd(A(2,2), d); check("R1 period t2", d, 33);
        rd(A(1,1), d); check("R10 count write ignored", d, 0);

        // R3 R4 R8 R9 directed waveform on timer 0
        wr(STAT, 32'h3F);
        wr(A(0,2), 6); wr(A(0,3), 2);
        wr(A(0,0), EN | WAVE | IEN);
        for (int j = 0; j <= 12; j++) begin
            rd(A(0,1), d); check("R3 wave count", d, j % 6);
            check("R3 wave level", pin_out[0], (j % 6) < 2);
            check("R4 R9 irq after period end", irq[0], j >= 6);
            rd(STAT, d); check("R8 status during wave", d, (j >= 6 ? 1 : 0) | (j >= 12 ? 8 : 0));
            rd(A(1,1), d); check("R1 other channel untouched", d, 0);
            @(negedge clk);
        end
        wr(A(0,0), 0);

        // R7 write-one-to-clear
        wr(STAT, 0);        rd(STAT, d); check("R7 zero write keeps flags", d, 32'h09);
        wr(STAT, 32'h08);   rd(STAT, d); check("R7 clear overflow only", d, 32'h01);
        wr(STAT, 32'h01);   rd(STAT, d); check("R7 clear event flag", d, 0);
        check("R9 irq drops with flag", irq[0], 1'b0);
        wr(A(2,2), 1);
        wr(A(2,0), EN | WAVE);
        repeat (2) @(negedge clk);
        wr(STAT, 32'h04);
        rd(STAT, d); check("R7 set wins over clear", d & 32'h04, 32'h04);
        wr(A(2,0), 0);
        wr(STAT, 32'h3F);
        rd(STAT, d); check("R7 all cleared", d, 0);

        // R3 random waveform scenarios
        for (int it = 0; it < 6; it++) begin
            int t, p, w;
            bit inv;
            t   = $urandom_range(0, 2);
            p   = $urandom_range(0, 10);
            w   = $urandom_range(0, p + 1);
            inv = 1'($urandom_range(0, 1));
            wr(A(t,2), p); wr(A(t,3), w);
            wr(A(t,0), EN | WAVE | (inv ? INV : 0));
            for (int j = 0; j < 25; j++) begin
                check("R3 random wave level", pin_out[t], exp_wave(j, p, w, inv));
                check("R1 other pins undriven", {29'd0, pin_oe}, 32'd1 << t);
                @(negedge clk);
            end
            wr(A(t,0), 0);
            rd(A(t,1), d); check("R2 disable clears count", d, 0);
            wr(STAT, 32'h3F);
        end

        // R5 capture, both polarities, random pulse shapes
        for (int it = 0; it < 4; it++) begin
            run_capture($urandom_range(0, 2), $urandom_range(1, 7), $urandom_range(1, 7),
                        1'(it % 2), 1'($urandom_range(0, 1)));
        end

        // R6 watchdog: exactly W edges then W-1 edges
        wr(A(1,2), 20); wr(A(1,3), 3);
        wr(A(1,0), EN | WDOG | IEN);
        for (int j = 0; j <= 41; j++) begin
            pin_in[1] = (j == 2 || j == 4 || j == 6 || j == 22 || j == 24);
            if (j == 19) begin rd(A(1,1), d); check("R6 window count", d, 19); end
            if (j == 25 || j == 39) begin
                rd(STAT, d); check("R6 no alarm with W edges", d, 0);
            end
            if (j == 40) begin
                rd(STAT, d); check("R6 alarm with W-1 edges", d, 32'h02);
                check("R9 watchdog irq", irq[1], 1'b1);
            end
            @(negedge clk);
        end
        wr(A(1,0), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule